// File: doc/BRIEF.md
# Target-Side Write and Doorbell Request Parser

This block sits on the inbound target-request stream of a serial packet interconnect endpoint. Each packet arrives as 64-bit beats: the first beat is a header and any beats after it, up to and including the one flagged with tlast, are payload. The block reads the transaction kind from the header. It sends posted and acknowledged write traffic to an address-and-data output port and sends doorbell events to a separate event port. It drops every other kind after counting it.

A length checker compares the payload beat count with the size field in the header. It pulses an error flag whenever the packet framing disagrees with that field, and it discards any surplus beats. When the response option is built in, the block also emits a one-beat completion on the target-response stream for every acknowledged write and every doorbell. While that completion waits for its consumer, the request stream is backpressured. Without the option, the request stream is always ready.

Top module: `tgt_req_parser`

## Requirements
- R1: Header fields are TID bits [63:56], FTYPE [55:52], TTYPE [51:48], size [43:36], address [33:0] and doorbell info [31:16]. FTYPE 5 with TTYPE 4 is a posted write, FTYPE 5 with TTYPE 5 is a write needing a response, and FTYPE 10 with TTYPE 0 is a doorbell. Every other pair is unsupported.
- R2: One cycle after a write header is accepted, `wr_addr_valid` pulses for one cycle with the header's address and TID.
- R3: One cycle after each accepted write payload beat, `wr_data_valid` pulses with that beat's data and with `s_keep` as the byte enables, in arrival order. `wr_data_last` is set on the beat that carries tlast or on the last expected beat, whichever comes first.
- R4: The size field holds the byte count minus one, up to 256 bytes. A write expects floor(size/8)+1 payload beats, so 1 to 32 beats.
- R5: One cycle after a doorbell header is accepted, `db_valid` pulses with the info value, the TID and the source ID. The source ID is the upper ID_W bits of `s_user`; the lower ID_W bits are the destination ID.
- R6: When a write ends with fewer payload beats than expected, `fmt_err` pulses for one cycle. This includes a write header that carries tlast itself.
- R7: When the last expected write payload beat lacks tlast, `fmt_err` pulses. The beats that follow, up to tlast, produce no output.
- R8: When a doorbell header lacks tlast, `fmt_err` pulses and the beats that follow, up to tlast, produce no output.
- R9: An unsupported packet is consumed through tlast with no output. It increments `unsup_cnt`, which saturates at its maximum value.
- R10: One cycle after the tlast beat of a write-with-response or a doorbell, `rsp_valid` rises with a one-beat response and `rsp_last` set. The response carries the request TID at [63:56], FTYPE 13 at [55:52], TTYPE 0 at [51:48] and status at [47:44]: 0 for done, or 7 if the packet had a format error. All other bits are zero. `rsp_user` holds the request's source and destination IDs swapped.
- R11: A pending response holds its data until `rsp_ready`. `s_ready` is low exactly while a response is valid and not being accepted.
- R12: After reset, all valid outputs and `fmt_err` are low, `unsup_cnt` is zero and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request beat valid |
| s_ready | output | 1 | Request beat accepted when high |
| s_data | input | 64 | Request beat, header or payload |
| s_keep | input | 8 | Byte-valid mask of the beat |
| s_last | input | 1 | Final beat of the packet |
| s_user | input | 2*ID_W | Source ID (upper) and destination ID (lower) |
| wr_addr_valid | output | 1 | Write address strobe |
| wr_addr | output | ADDR_W | Write target address |
| wr_tid | output | 8 | Write transaction ID |
| wr_data_valid | output | 1 | Write payload word valid |
| wr_data | output | 64 | Write payload word |
| wr_be | output | 8 | Byte enables of the payload word |
| wr_data_last | output | 1 | Final forwarded payload word |
| db_valid | output | 1 | Doorbell event strobe |
| db_info | output | 16 | Doorbell info value |
| db_tid | output | 8 | Doorbell transaction ID |
| db_src | output | ID_W | Doorbell source ID |
| fmt_err | output | 1 | Framing error pulse |
| unsup_cnt | output | CNT_W | Saturating count of unsupported packets |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat accepted |
| rsp_data | output | 64 | Response header beat |
| rsp_last | output | 1 | Response end, set with every response beat |
| rsp_user | output | 2*ID_W | Swapped source and destination IDs |

## Verification
The bench builds the block with 16-bit IDs, the full 34-bit address, the response option on, and a 2-bit unsupported counter. The narrow counter lets four unsupported packets drive it into saturation. With the response path present, a slowed `rsp_ready` exercises request backpressure while responses wait. Packets range from a full 256-byte write to short, long and zero-payload writes and to a doorbell with trailing beats.

// File: rtl/trq_pkg.sv
package trq_pkg;

   localparam int BEAT_W     = 64;
   localparam int KEEP_W     = BEAT_W / 8;
   localparam int MAX_BYTES  = 256;
   localparam int MAX_BEATS  = MAX_BYTES / KEEP_W;
   localparam int BEAT_CNT_W = $clog2(MAX_BEATS + 1);

   typedef enum logic [1:0] {
      K_WRITE,
      K_WRITE_RSP,
      K_DOORBELL,
      K_OTHER
   } pkt_kind_e;

   localparam logic [3:0] FT_WRITE   = 4'h5;
   localparam logic [3:0] TT_POSTED  = 4'h4;
   localparam logic [3:0] TT_ACKED   = 4'h5;
   localparam logic [3:0] FT_DBELL   = 4'hA;
   localparam logic [3:0] TT_DBELL   = 4'h0;
   localparam logic [3:0] FT_RESP    = 4'hD;
   localparam logic [3:0] TT_RESP_ND = 4'h0;
   localparam logic [3:0] ST_DONE    = 4'h0;
   localparam logic [3:0] ST_ERROR   = 4'h7;

   function automatic logic [BEAT_CNT_W-1:0] beats_for_size(input logic [7:0] sz);
      return BEAT_CNT_W'(sz[7:3]) + BEAT_CNT_W'(1);
   endfunction

endpackage

// File: rtl/trq_hdr_decode.sv
module trq_hdr_decode
   import trq_pkg::*;
#(
   parameter int ADDR_W = 34
) (
   input  logic [BEAT_W-1:0]     hdr,
   output pkt_kind_e             kind,
   output logic [7:0]            tid,
   output logic [ADDR_W-1:0]     addr,
   output logic [15:0]           info,
   output logic [BEAT_CNT_W-1:0] exp_beats
);

   logic [3:0] ftype;
   logic [3:0] ttype;
   logic       unused_hdr;

   assign ftype      = hdr[55:52];
   assign ttype      = hdr[51:48];
   assign tid        = hdr[63:56];
   assign addr       = hdr[ADDR_W-1:0];
   assign info       = hdr[31:16];
   assign exp_beats  = beats_for_size(hdr[43:36]);
   assign unused_hdr = ^hdr;

   always_comb begin
      kind = K_OTHER;
      if (ftype == FT_WRITE && ttype == TT_POSTED)     kind = K_WRITE;
      else if (ftype == FT_WRITE && ttype == TT_ACKED) kind = K_WRITE_RSP;
      else if (ftype == FT_DBELL && ttype == TT_DBELL) kind = K_DOORBELL;
   end

endmodule

// File: rtl/trq_len_track.sv
module trq_len_track
   import trq_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  beat,
   input  logic                  last,
   input  pkt_kind_e             kind,
   input  logic [BEAT_CNT_W-1:0] exp_beats,
   output logic                  hdr_beat,
   output logic                  body_fwd,
   output logic                  body_end,
   output logic                  err_now,
   output logic                  pkt_done,
   output logic                  pkt_bad
);

   typedef enum logic [1:0] {S_HDR, S_BODY, S_DROP} trk_state_e;

   localparam logic [BEAT_CNT_W-1:0] ONE = BEAT_CNT_W'(1);

   trk_state_e            st, st_nx;
   logic [BEAT_CNT_W-1:0] rem, rem_nx;
   logic                  bad_q;

   always_comb begin
      st_nx    = st;
      rem_nx   = rem;
      err_now  = 1'b0;
      hdr_beat = beat && (st == S_HDR);
      body_fwd = beat && (st == S_BODY);
      body_end = body_fwd && (last || rem == ONE);
      pkt_done = beat && last;
      if (beat) begin
         unique case (st)
            S_HDR: begin
               unique case (kind)
                  K_WRITE, K_WRITE_RSP: begin
                     if (last) err_now = 1'b1;
                     else begin
                        st_nx  = S_BODY;
                        rem_nx = exp_beats;
                     end
                  end
                  K_DOORBELL: begin
                     if (!last) begin
                        err_now = 1'b1;
                        st_nx   = S_DROP;
                     end
                  end
                  default: begin
                     if (!last) st_nx = S_DROP;
                  end
               endcase
            end
            S_BODY: begin
               if (last) begin
                  err_now = (rem != ONE);
                  st_nx   = S_HDR;
               end else if (rem == ONE) begin
                  err_now = 1'b1;
                  st_nx   = S_DROP;
               end else begin
                  rem_nx = rem - ONE;
               end
            end
            default: begin
               if (last) st_nx = S_HDR;
            end
         endcase
      end
      pkt_bad = bad_q | err_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= S_HDR;
         rem   <= '0;
         bad_q <= 1'b0;
      end else begin
         st    <= st_nx;
         rem   <= rem_nx;
         bad_q <= pkt_done ? 1'b0 : (bad_q | err_now);
      end
   end

endmodule

// File: rtl/trq_resp_gen.sv
module trq_resp_gen
   import trq_pkg::*;
#(
   parameter int ID_W = 16,
   parameter int EN   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [7:0]        tid,
   input  logic              bad,
   input  logic [ID_W-1:0]   req_src,
   input  logic [ID_W-1:0]   req_dst,
   input  logic              rsp_ready,
   output logic              rsp_valid,
   output logic [BEAT_W-1:0] rsp_data,
   output logic              rsp_last,
   output logic [2*ID_W-1:0] rsp_user,
   output logic              slot_free
);

   generate
      if (EN != 0) begin : g_on
         logic [BEAT_W-1:0] beat_nx;

         always_comb begin
            beat_nx        = '0;
            beat_nx[63:56] = tid;
            beat_nx[55:52] = FT_RESP;
            beat_nx[51:48] = TT_RESP_ND;
            beat_nx[47:44] = bad ? ST_ERROR : ST_DONE;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rsp_valid <= 1'b0;
               rsp_data  <= '0;
               rsp_user  <= '0;
            end else if (load) begin
               rsp_valid <= 1'b1;
               rsp_data  <= beat_nx;
               rsp_user  <= {req_dst, req_src};
            end else if (rsp_ready) begin
               rsp_valid <= 1'b0;
            end
         end

         assign rsp_last  = rsp_valid;
         assign slot_free = !rsp_valid || rsp_ready;
      end else begin : g_off
         logic unused_in;
         assign unused_in = ^{clk, rst_n, load, tid, bad, req_src, req_dst, rsp_ready};
         assign rsp_valid = 1'b0;
         assign rsp_data  = '0;
         assign rsp_last  = 1'b0;
         assign rsp_user  = '0;
         assign slot_free = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/tgt_req_parser.sv
module tgt_req_parser
   import trq_pkg::*;
#(
   parameter int ID_W    = 16,
   parameter int ADDR_W  = 34,
   parameter int CNT_W   = 16,
   parameter int RESP_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [63:0]       s_data,
   input  logic [7:0]        s_keep,
   input  logic              s_last,
   input  logic [2*ID_W-1:0] s_user,
   output logic              wr_addr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_tid,
   output logic              wr_data_valid,
   output logic [63:0]       wr_data,
   output logic [7:0]        wr_be,
   output logic              wr_data_last,
   output logic              db_valid,
   output logic [15:0]       db_info,
   output logic [7:0]        db_tid,
   output logic [ID_W-1:0]   db_src,
   output logic              fmt_err,
   output logic [CNT_W-1:0]  unsup_cnt,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [63:0]       rsp_data,
   output logic              rsp_last,
   output logic [2*ID_W-1:0] rsp_user
);

   generate
      if (!(ID_W == 8 || ID_W == 16)) begin : g_bad_id
         $error("tgt_req_parser: ID_W must be 8 or 16");
      end
      if (ADDR_W < 1 || ADDR_W > 34) begin : g_bad_addr
         $error("tgt_req_parser: ADDR_W must lie in 1..34");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("tgt_req_parser: CNT_W must be positive");
      end
      if (BEAT_W != 64 || KEEP_W != 8) begin : g_bad_beat
         $error("tgt_req_parser: header layout needs 64-bit beats");
      end
   endgenerate

   logic                  beat;
   logic                  slot_free;
   pkt_kind_e             dec_kind;
   logic [7:0]            dec_tid;
   logic [ADDR_W-1:0]     dec_addr;
   logic [15:0]           dec_info;
   logic [BEAT_CNT_W-1:0] dec_beats;
   logic                  hdr_beat, body_fwd, body_end, err_now, pkt_done, pkt_bad;
   logic [ID_W-1:0]       in_src, in_dst;

   pkt_kind_e             cur_kind;
   logic [7:0]            cur_tid;
   logic [ID_W-1:0]       cur_src, cur_dst;

   pkt_kind_e             ctx_kind;
   logic [7:0]            ctx_tid;
   logic [ID_W-1:0]       ctx_src, ctx_dst;
   logic                  rsp_load;

   assign s_ready = slot_free;
   assign beat    = s_valid && s_ready;
   assign in_src  = s_user[2*ID_W-1:ID_W];
   assign in_dst  = s_user[ID_W-1:0];

   trq_hdr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .hdr       (s_data),
      .kind      (dec_kind),
      .tid       (dec_tid),
      .addr      (dec_addr),
      .info      (dec_info),
      .exp_beats (dec_beats)
   );

   trq_len_track u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat      (beat),
      .last      (s_last),
      .kind      (dec_kind),
      .exp_beats (dec_beats),
      .hdr_beat  (hdr_beat),
      .body_fwd  (body_fwd),
      .body_end  (body_end),
      .err_now   (err_now),
      .pkt_done  (pkt_done),
      .pkt_bad   (pkt_bad)
   );

   // packet context: header values on the header beat, held values afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_kind <= K_OTHER;
         cur_tid  <= '0;
         cur_src  <= '0;
         cur_dst  <= '0;
      end else if (hdr_beat) begin
         cur_kind <= dec_kind;
         cur_tid  <= dec_tid;
         cur_src  <= in_src;
         cur_dst  <= in_dst;
      end
   end

   assign ctx_kind = hdr_beat ? dec_kind : cur_kind;
   assign ctx_tid  = hdr_beat ? dec_tid  : cur_tid;
   assign ctx_src  = hdr_beat ? in_src   : cur_src;
   assign ctx_dst  = hdr_beat ? in_dst   : cur_dst;
   assign rsp_load = pkt_done && (ctx_kind == K_WRITE_RSP || ctx_kind == K_DOORBELL);

   // write address and doorbell event outputs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_addr_valid <= 1'b0;
         wr_addr       <= '0;
         wr_tid        <= '0;
         db_valid      <= 1'b0;
         db_info       <= '0;
         db_tid        <= '0;
         db_src        <= '0;
      end else begin
         wr_addr_valid <= hdr_beat && (dec_kind == K_WRITE || dec_kind == K_WRITE_RSP);
         db_valid      <= hdr_beat && (dec_kind == K_DOORBELL);
         if (hdr_beat) begin
            wr_addr <= dec_addr;
            wr_tid  <= dec_tid;
            db_info <= dec_info;
            db_tid  <= dec_tid;
            db_src  <= in_src;
         end
      end
   end

   // payload word output
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_data_valid <= 1'b0;
         wr_data       <= '0;
         wr_be         <= '0;
         wr_data_last  <= 1'b0;
      end else begin
         wr_data_valid <= body_fwd;
         wr_data_last  <= body_end;
         if (body_fwd) begin
            wr_data <= s_data;
            wr_be   <= s_keep;
         end
      end
   end

   // error pulse and saturating unsupported counter
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_err   <= 1'b0;
         unsup_cnt <= '0;
      end else begin
         fmt_err <= err_now;
         if (hdr_beat && dec_kind == K_OTHER && unsup_cnt != '1)
            unsup_cnt <= unsup_cnt + CNT_W'(1);
      end
   end

   trq_resp_gen #(.ID_W(ID_W), .EN(RESP_EN)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rsp_load),
      .tid       (ctx_tid),
      .bad       (pkt_bad),
      .req_src   (ctx_src),
      .req_dst   (ctx_dst),
      .rsp_ready (rsp_ready),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_last  (rsp_last),
      .rsp_user  (rsp_user),
      .slot_free (slot_free)
   );

endmodule

// File: rtl/trq_parser_chk.sv
module trq_parser_chk #(
   parameter int ID_W  = 16,
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic              wr_addr_valid,
   input logic              wr_data_valid,
   input logic              db_valid,
   input logic [CNT_W-1:0]  unsup_cnt,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [63:0]       rsp_data,
   input logic [2*ID_W-1:0] rsp_user
);

   // R11
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_user));

   // R11
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ready |-> rsp_valid && !rsp_ready);

   // R9
   unsup_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_cnt != $past(unsup_cnt) |-> unsup_cnt == $past(unsup_cnt) + CNT_W'(1));

   // R5
   db_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |-> !wr_data_valid && !wr_addr_valid);

   // R2
   addr_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_addr_valid |-> !wr_data_valid);

endmodule

bind tgt_req_parser trq_parser_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .s_ready       (s_ready),
   .wr_addr_valid (wr_addr_valid),
   .wr_data_valid (wr_data_valid),
   .db_valid      (db_valid),
   .unsup_cnt     (unsup_cnt),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_data      (rsp_data),
   .rsp_user      (rsp_user)
);

// File: tb/sim_tgt_req_parser.sv
`timescale 1ns/1ps
module sim_tgt_req_parser;

   localparam int ID_W   = 16;
   localparam int ADDR_W = 34;
   localparam int CNT_W  = 2;
   localparam logic [15:0] SRC = 16'h00AA;
   localparam logic [15:0] DST = 16'h00BB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              s_valid = 1'b0;
   logic              s_ready;
   logic [63:0]       s_data = '0;
   logic [7:0]        s_keep = '0;
   logic              s_last = 1'b0;
   logic [2*ID_W-1:0] s_user = '0;
   logic              wr_addr_valid, wr_data_valid, wr_data_last, db_valid, fmt_err;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_tid, wr_be, db_tid;
   logic [63:0]       wr_data, rsp_data;
   logic [15:0]       db_info;
   logic [ID_W-1:0]   db_src;
   logic [CNT_W-1:0]  unsup_cnt;
   logic              rsp_valid, rsp_last;
   logic              rsp_ready = 1'b1;
   logic [2*ID_W-1:0] rsp_user;

   tgt_req_parser #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESP_EN(1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep),
      .s_last(s_last), .s_user(s_user),
      .wr_addr_valid(wr_addr_valid), .wr_addr(wr_addr), .wr_tid(wr_tid),
      .wr_data_valid(wr_data_valid), .wr_data(wr_data), .wr_be(wr_be),
      .wr_data_last(wr_data_last),
      .db_valid(db_valid), .db_info(db_info), .db_tid(db_tid), .db_src(db_src),
      .fmt_err(fmt_err), .unsup_cnt(unsup_cnt),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .rsp_last(rsp_last), .rsp_user(rsp_user)
   );

   int n_chk = 0;
   int n_fail = 0;
   int err_seen = 0;
   int err_exp = 0;
   int unsup_exp = 0;
   int cyc = 0;
   bit slow_rsp = 1'b0;
   bit done = 1'b0;

   logic [41:0] q_addr[$];
   logic [72:0] q_data[$];
   logic [39:0] q_db[$];
   logic [95:0] q_rsp[$];

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 rsp_ready = !slow_rsp || (cyc % 3 == 0);
   end

   function automatic logic [63:0] mk_hdr(input logic [7:0] tid, input logic [3:0] ft,
                                          input logic [3:0] tt, input logic [7:0] sz,
                                          input logic [33:0] addr, input logic [15:0] info);
      logic [63:0] h;
      h = '0;
      h[63:56] = tid;
      h[55:52] = ft;
      h[51:48] = tt;
      h[43:36] = sz;
      h[33:0]  = addr;
      if (ft == 4'hA) h[31:16] = info;
      return h;
   endfunction

   function automatic logic [63:0] mk_word(input logic [7:0] tid, input int i);
      return {tid, 24'h0, 32'(i + 1)};
   endfunction

   function automatic logic [63:0] mk_rsp(input logic [7:0] tid, input bit bad);
      logic [63:0] r;
      r = '0;
      r[63:56] = tid;
      r[55:52] = 4'hD;
      r[47:44] = bad ? 4'h7 : 4'h0;
      return r;
   endfunction

   task automatic drive_beat(input logic [63:0] d, input logic [7:0] k, input bit l);
      @(negedge clk);
      s_valid = 1'b1; s_data = d; s_keep = k; s_last = l; s_user = {SRC, DST};
      #1;
      while (!s_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 s_valid = 1'b0;
   endtask

   task automatic send_write(input logic [7:0] tid, input bit acked, input logic [33:0] addr,
                             input logic [7:0] sz, input int sent, input logic [7:0] kl);
      int need, fwd;
      bit bad;
      need = int'(sz) / 8 + 1;
      fwd  = (sent < need) ? sent : need;
      bad  = (sent != need);
      q_addr.push_back({tid, addr});
      for (int i = 0; i < fwd; i++)
         q_data.push_back({mk_word(tid, i), (i == sent - 1) ? kl : 8'hFF, i == fwd - 1});
      if (bad) err_exp++;
      if (acked) q_rsp.push_back({mk_rsp(tid, bad), DST, SRC});
      drive_beat(mk_hdr(tid, 4'h5, acked ? 4'h5 : 4'h4, sz, addr, 16'h0), 8'hFF, sent == 0);
      for (int i = 0; i < sent; i++)
         drive_beat(mk_word(tid, i), (i == sent - 1) ? kl : 8'hFF, i == sent - 1);
   endtask

   task automatic send_db(input logic [7:0] tid, input logic [15:0] info, input int extra);
      q_db.push_back({info, tid, SRC});
      if (extra != 0) err_exp++;
      q_rsp.push_back({mk_rsp(tid, extra != 0), DST, SRC});
      drive_beat(mk_hdr(tid, 4'hA, 4'h0, 8'h0, 34'h0, info), 8'hFF, extra == 0);
      for (int i = 0; i < extra; i++) drive_beat(mk_word(tid, i), 8'hFF, i == extra - 1);
   endtask

   task automatic send_other(input logic [3:0] ft, input logic [3:0] tt, input int extra);
      if (unsup_exp < (1 << CNT_W) - 1) unsup_exp++;
      drive_beat(mk_hdr(8'h77, ft, tt, 8'h0, 34'h0, 16'h0), 8'hFF, extra == 0);
      for (int i = 0; i < extra; i++) drive_beat(mk_word(8'h77, i), 8'hFF, i == extra - 1);
   endtask

   task automatic settle(input string req);
      repeat (8) @(negedge clk);
      check(err_seen == err_exp, req, 128'(err_seen), 128'(err_exp));
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      logic [41:0] ea;
      logic [72:0] ed;
      logic [39:0] eb;
      logic [95:0] er;
      if (rst_n) begin
         check(s_ready == !(rsp_valid && !rsp_ready), "R11 s_ready", 128'(s_ready),
               128'(!(rsp_valid && !rsp_ready)));
         if (fmt_err) err_seen++;
         if (wr_addr_valid) begin
            if (q_addr.size() == 0) check(1'b0, "R2 unexpected address", 128'({wr_tid, wr_addr}), 0);
            else begin
               ea = q_addr.pop_front();
               check({wr_tid, wr_addr} == ea, "R2 address", 128'({wr_tid, wr_addr}), 128'(ea));
            end
         end
         if (wr_data_valid) begin
            if (q_data.size() == 0) check(1'b0, "R3 unexpected data", 128'(wr_data), 0);
            else begin
               ed = q_data.pop_front();
               check({wr_data, wr_be, wr_data_last} == ed, "R3 payload",
                     128'({wr_data, wr_be, wr_data_last}), 128'(ed));
            end
         end
         if (db_valid) begin
            if (q_db.size() == 0) check(1'b0, "R5 unexpected doorbell", 128'(db_info), 0);
            else begin
               eb = q_db.pop_front();
               check({db_info, db_tid, db_src} == eb, "R5 doorbell",
                     128'({db_info, db_tid, db_src}), 128'(eb));
            end
         end
         if (rsp_valid && rsp_ready) begin
            if (q_rsp.size() == 0) check(1'b0, "R10 unexpected response", 128'(rsp_data), 0);
            else begin
               er = q_rsp.pop_front();
               check({rsp_data, rsp_user} == er && rsp_last, "R10 response",
                     128'({rsp_data, rsp_user}), 128'(er));
            end
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12 reset state
      check(!wr_addr_valid && !wr_data_valid && !db_valid && !rsp_valid && !fmt_err,
            "R12 valids low", 128'({wr_addr_valid, wr_data_valid, db_valid, rsp_valid, fmt_err}), 0);
      check(unsup_cnt == 0, "R12 unsup_cnt", 128'(unsup_cnt), 0);
      check(s_ready == 1'b1, "R12 s_ready", 128'(s_ready), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 full 256-byte write, 32 beats
      send_write(8'h01, 1'b0, 34'h001000000, 8'd255, 32, 8'hFF);
      settle("R4 full write no error");
      // R1 R3 acked write with partial last keep, slow response consumer
      slow_rsp = 1'b1;
      send_write(8'h02, 1'b1, 34'h001000100, 8'd20, 3, 8'h1F);
      // R5 R10 doorbell info 0x0001, then back-to-back write under backpressure
      send_db(8'h03, 16'h0001, 0);
      send_write(8'h04, 1'b1, 34'h000000200, 8'd15, 2, 8'hFF);
      settle("R1 clean packets");
      slow_rsp = 1'b0;
      // R6 short acked write: 4 expected, 2 sent
      send_write(8'h05, 1'b1, 34'h000000300, 8'd31, 2, 8'hFF);
      settle("R6 short write");
      // R6 zero-payload write
      send_write(8'h06, 1'b0, 34'h000000400, 8'd7, 0, 8'hFF);
      settle("R6 header-only write");
      // R7 long write: 1 expected, 3 sent
      send_write(8'h07, 1'b0, 34'h000000500, 8'd7, 3, 8'hFF);
      settle("R7 long write");
      // R8 doorbell with two trailing beats
      send_db(8'h08, 16'hBEEF, 2);
      settle("R8 doorbell trailing beats");
      // R9 unsupported packets
      send_other(4'h2, 4'h4, 0);
      send_other(4'h6, 4'h0, 3);
      settle("R9 no error on unsupported");
      check(unsup_cnt == CNT_W'(unsup_exp), "R9 count", 128'(unsup_cnt), 128'(unsup_exp));
      check(q_addr.size() == 0 && q_data.size() == 0 && q_db.size() == 0,
            "R9 no output", 128'(q_addr.size() + q_data.size() + q_db.size()), 0);
      send_other(4'h5, 4'h6, 1);
      send_other(4'hA, 4'h1, 0);
      settle("R9 saturation");
      check(unsup_cnt == CNT_W'(unsup_exp), "R9 saturated", 128'(unsup_cnt), 128'(unsup_exp));
      // R2 parser resynchronises after drops
      send_write(8'h09, 1'b1, 34'h3FFFFFFF8, 8'd63, 8, 8'h0F);
      settle("R2 recovery write");

      check(q_addr.size() == 0, "R2 addresses drained", 128'(q_addr.size()), 0);
      check(q_data.size() == 0, "R3 payload drained", 128'(q_data.size()), 0);
      check(q_db.size() == 0, "R5 doorbells drained", 128'(q_db.size()), 0);
      check(q_rsp.size() == 0, "R10 responses drained", 128'(q_rsp.size()), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule